// File: doc/BRIEF.md
# Segment Descriptor Translation Stage

This block turns a segmented logical address into a flat linear address ahead of the paging stage. A request carries a 13-bit segment selector, a 32-bit offset and an access kind. The block first checks the selector against the segment table length register. If the selector is in range, it reads a two-word descriptor from the table in memory, located through the segment table base register. It then checks the offset against the descriptor's limit and the access kind against the descriptor's write permission. The result is either a linear address or a 2-bit trap code.

The block takes one request at a time. It samples the table base and length when it accepts a request. It reads the descriptor through a simple request/response memory port, and it presents the result for exactly one cycle. The paging stage, privilege levels and any caching of descriptors live outside this block.

Top module: `seg_xlate`

## Requirements
- R1: After reset `out_valid` and `mem_req_valid` are low and `req_ready` is high.
- R2: A selector greater than or equal to `tbl_len` produces trap code 1 and issues no memory read at all.
- R3: For a selector in range the block issues exactly two reads, in order: address `tbl_base + 8*seg` (the base word), then that address plus 4 (the limit/permission word).
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays high and its address stays unchanged.
- R5: The limit is held in bits 31:1 of the second descriptor word. An offset greater than the limit, compared as unsigned 32-bit values, produces trap code 2.
- R6: An offset equal to the limit is accepted.
- R7: Bit 0 of the second descriptor word set to 1 marks the segment read-only. A write access (kind 1) that passes the limit check then produces trap code 3. Reads (kind 0), fetches (kind 2) and kind 3, which is treated as a read, are not affected by this bit.
- R8: When the limit check takes precedence, a write that is both past the limit and to a read-only segment reports code 2.
- R9: With no trap the code is 0 and `out_lin` equals the base word plus the offset modulo 2^32.
- R10: Each accepted request yields exactly one single-cycle `out_valid` pulse. `req_ready` stays low from acceptance until that pulse has gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_seg | input | 13 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| tbl_base | input | 32 | Byte address of descriptor 0 |
| tbl_len | input | 13 | Number of descriptors in the table |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| out_valid | output | 1 | Result pulse |
| out_trap | output | 2 | 0 none, 1 bad selector, 2 limit, 3 protection |
| out_lin | output | 32 | Linear address, meaningful when the trap code is 0 |

## Verification
The control state is the main thing that can go wrong. A state that skips or repeats a descriptor read shows at the memory port on the very next handshake, as a read count other than zero or two or as the wrong word address. A stuck or mislatched descriptor register shows at the single result pulse, a few cycles after the second response, as a wrong trap code or linear address. The sweep covers every selector around the table length, offsets at and just past each limit, and all four access kinds. It also uses one segment with the largest limit, so that the base-plus-offset wrap is exposed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      TRAP_NONE  = 2'd0,
      TRAP_SEG   = 2'd1,
      TRAP_LIMIT = 2'd2,
      TRAP_PROT  = 2'd3
   } trap_e;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_ALT   = 2'd3
   } kind_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD_LO = 3'd1,
      ST_WT_LO = 3'd2,
      ST_RD_HI = 3'd3,
      ST_WT_HI = 3'd4,
      ST_DONE  = 3'd5
   } state_e;

endpackage

// File: rtl/seg_xlate_agen.sv
module seg_xlate_agen #(
   parameter int SEG_W   = 13,
   parameter int ADDR_W  = 32,
   parameter int WORD_B  = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [SEG_W-1:0]  seg,
   input  logic              hi_word,
   output logic [ADDR_W-1:0] addr
);
   localparam int DESC_B   = 2 * WORD_B;
   localparam int SHIFT    = $clog2(DESC_B);
   localparam int PAD_W    = ADDR_W - SEG_W - SHIFT;

   generate
      if (PAD_W < 0) begin : g_bad_width
         $error("seg_xlate_agen: selector does not fit the address width");
      end
      if ((1 << SHIFT) != DESC_B) begin : g_bad_desc
         $error("seg_xlate_agen: descriptor size must be a power of two");
      end
   endgenerate

   logic [ADDR_W-1:0] index_off;
   logic [ADDR_W-1:0] word_off;

   always_comb begin
      index_off = ADDR_W'(seg) << SHIFT;
      word_off  = hi_word ? ADDR_W'(WORD_B) : '0;
      addr      = base + index_off + word_off;
   end
endmodule

// File: rtl/seg_xlate_judge.sv
module seg_xlate_judge
   import seg_xlate_pkg::*;
#(
   parameter int OFF_W    = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32,
   parameter bit WRITE_PROT = 1'b1
) (
   input  logic              bad_seg,
   input  logic [OFF_W-1:0]  offset,
   input  logic [1:0]        kind,
   input  logic [DATA_W-1:0] base_word,
   input  logic [DATA_W-1:0] attr_word,
   output logic [1:0]        trap,
   output logic [ADDR_W-1:0] lin
);
   localparam int LIM_W = DATA_W - 1;

   generate
      if (OFF_W > DATA_W) begin : g_bad_off
         $error("seg_xlate_judge: offset wider than descriptor word");
      end
   endgenerate

   logic [LIM_W-1:0]  limit;
   logic              ro_flag;
   logic              past_limit;
   logic              prot_hit;

   assign limit   = attr_word[DATA_W-1:1];
   assign ro_flag = attr_word[0];

   always_comb begin
      past_limit = DATA_W'(offset) > {1'b0, limit};
   end

   generate
      if (WRITE_PROT) begin : g_prot
         assign prot_hit = ro_flag && (kind == KIND_WRITE);
      end else begin : g_noprot
         assign prot_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      lin = ADDR_W'(base_word) + ADDR_W'(offset);
      if (bad_seg)         trap = TRAP_SEG;
      else if (past_limit) trap = TRAP_LIMIT;
      else if (prot_hit)   trap = TRAP_PROT;
      else                 trap = TRAP_NONE;
   end
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W  = 13,
   parameter int OFF_W  = 32,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [SEG_W-1:0]  tbl_len,
   output logic              rd_valid,
   output logic              rd_hi,
   input  logic              rd_ready,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              done,
   output logic              bad_seg,
   output logic [SEG_W-1:0]  seg_q,
   output logic [OFF_W-1:0]  off_q,
   output logic [1:0]        kind_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [DATA_W-1:0] word_lo,
   output logic [DATA_W-1:0] word_hi
);
   state_e state;
   logic   accept;
   logic   in_range;

   assign accept   = req_valid && (state == ST_IDLE);
   assign in_range = req_seg < tbl_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bad_seg <= 1'b0;
         seg_q   <= '0;
         off_q   <= '0;
         kind_q  <= '0;
         base_q  <= '0;
         word_lo <= '0;
         word_hi <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               seg_q   <= req_seg;
               off_q   <= req_off;
               kind_q  <= req_kind;
               base_q  <= tbl_base;
               bad_seg <= !in_range;
               state   <= in_range ? ST_RD_LO : ST_DONE;
            end
            ST_RD_LO: if (rd_ready) state <= ST_WT_LO;
            ST_WT_LO: if (rsp_valid) begin
               word_lo <= rsp_data;
               state   <= ST_RD_HI;
            end
            ST_RD_HI: if (rd_ready) state <= ST_WT_HI;
            ST_WT_HI: if (rsp_valid) begin
               word_hi <= rsp_data;
               state   <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rd_valid  = (state == ST_RD_LO) || (state == ST_RD_HI);
   assign rd_hi     = (state == ST_RD_HI);
   assign done      = (state == ST_DONE);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W      = 13,
   parameter int OFF_W      = 32,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter bit WRITE_PROT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [SEG_W-1:0]  tbl_len,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              out_valid,
   output logic [1:0]        out_trap,
   output logic [ADDR_W-1:0] out_lin
);
   localparam int WORD_B = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("seg_xlate: descriptor word must be whole bytes");
      end
      if (SEG_W < 1) begin : g_bad_seg
         $error("seg_xlate: selector width must be positive");
      end
   endgenerate

   logic              rd_hi;
   logic              done;
   logic              bad_seg;
   logic [SEG_W-1:0]  seg_q;
   logic [OFF_W-1:0]  off_q;
   logic [1:0]        kind_q;
   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] word_lo;
   logic [DATA_W-1:0] word_hi;

   seg_xlate_ctrl #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_seg(req_seg), .req_off(req_off), .req_kind(req_kind),
      .tbl_base(tbl_base), .tbl_len(tbl_len),
      .rd_valid(mem_req_valid), .rd_hi(rd_hi), .rd_ready(mem_req_ready),
      .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
      .done(done), .bad_seg(bad_seg),
      .seg_q(seg_q), .off_q(off_q), .kind_q(kind_q), .base_q(base_q),
      .word_lo(word_lo), .word_hi(word_hi)
   );

   seg_xlate_agen #(
      .SEG_W(SEG_W), .ADDR_W(ADDR_W), .WORD_B(WORD_B)
   ) u_agen (
      .base(base_q), .seg(seg_q), .hi_word(rd_hi), .addr(mem_req_addr)
   );

   seg_xlate_judge #(
      .OFF_W(OFF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WRITE_PROT(WRITE_PROT)
   ) u_judge (
      .bad_seg(bad_seg), .offset(off_q), .kind(kind_q),
      .base_word(word_lo), .attr_word(word_hi),
      .trap(out_trap), .lin(out_lin)
   );

   assign out_valid = done;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int SEG_W  = 13,
   parameter int OFF_W  = 32,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [SEG_W-1:0]  req_seg,
   input logic [OFF_W-1:0]  req_off,
   input logic [ADDR_W-1:0] tbl_base,
   input logic [SEG_W-1:0]  tbl_len,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rsp_valid,
   input logic [DATA_W-1:0] mem_rsp_data,
   input logic              out_valid,
   input logic [1:0]        out_trap,
   input logic [ADDR_W-1:0] out_lin
);
   logic [SEG_W-1:0]  c_seg;
   logic [OFF_W-1:0]  c_off;
   logic [ADDR_W-1:0] c_base;
   logic              c_bad;
   logic [1:0]        c_reads;
   logic              c_got_lo;
   logic [DATA_W-1:0] c_lo;
   logic [ADDR_W-1:0] c_expaddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_seg <= '0; c_off <= '0; c_base <= '0; c_bad <= 1'b0;
         c_reads <= '0; c_got_lo <= 1'b0; c_lo <= '0;
      end else if (req_valid && req_ready) begin
         c_seg    <= req_seg;
         c_off    <= req_off;
         c_base   <= tbl_base;
         c_bad    <= !(req_seg < tbl_len);
         c_reads  <= '0;
         c_got_lo <= 1'b0;
      end else begin
         if (mem_req_valid && mem_req_ready) c_reads <= c_reads + 2'd1;
         if (mem_rsp_valid && !c_got_lo) begin
            c_got_lo <= 1'b1;
            c_lo     <= mem_rsp_data;
         end
      end
   end

   assign c_expaddr = c_base + (ADDR_W'(c_seg) << 3) + ((c_reads != 2'd0) ? ADDR_W'(4) : '0);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!out_valid && !mem_req_valid && req_ready));

   assert_no_read_bad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      c_bad |-> !mem_req_valid);

   assert_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && c_bad) |-> (out_trap == 2'd1));

   assert_word_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr == c_expaddr && c_reads < 2'd2));

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_lin_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_trap == 2'd0) |-> (out_lin == c_lo + ADDR_W'(c_off)));

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

bind seg_xlate seg_xlate_chk #(
   .SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready),
   .req_seg(req_seg), .req_off(req_off),
   .tbl_base(tbl_base), .tbl_len(tbl_len),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr),
   .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
   .out_valid(out_valid), .out_trap(out_trap), .out_lin(out_lin)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [12:0] req_seg = '0;
   logic [31:0] req_off = '0;
   logic [1:0]  req_kind = '0;
   logic [31:0] tbl_base = 32'h0000_0400;
   logic [12:0] tbl_len = 13'd12;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        out_valid;
   logic [1:0]  out_trap;
   logic [31:0] out_lin;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int hs_n = 0;
   logic [31:0] hs_addr0, hs_addr1;
   logic        pend = 1'b0;
   logic [31:0] paddr = '0;

   always #2.5 clk = ~clk;

   seg_xlate u_seg_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_seg(req_seg), .req_off(req_off), .req_kind(req_kind),
      .tbl_base(tbl_base), .tbl_len(tbl_len),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .out_valid(out_valid), .out_trap(out_trap), .out_lin(out_lin)
   );

   function automatic logic [30:0] lim_of(int i);
      return (i == 7) ? 31'h7FFF_FFFF : 31'(i * 37 + 5);
   endfunction
   function automatic logic [31:0] base_of(int i);
      return 32'hF000_0000 + 32'(i) * 32'h0001_1000;
   endfunction
   function automatic logic [31:0] mem_word(logic [31:0] a);
      logic [31:0] rel;
      int idx;
      rel = a - tbl_base;
      idx = int'(rel >> 3);
      if (rel[2]) return {lim_of(idx), 1'(idx % 2)};
      return base_of(idx);
   endfunction

   // memory model: handshake seen at the edge, answer placed at the next falling edge
   always @(posedge clk) begin
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (hs_n == 0) hs_addr0 = mem_req_addr;
         if (hs_n == 1) hs_addr1 = mem_req_addr;
         hs_n  = hs_n + 1;
         pend  = 1'b1;
         paddr = mem_req_addr;
      end
   end
   always @(negedge clk) begin
      cyc = cyc + 1;
      mem_req_ready = (cyc % 3) != 1;
      mem_rsp_valid = pend;
      mem_rsp_data  = pend ? mem_word(paddr) : 32'h0;
      pend = 1'b0;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input int seg, input logic [31:0] off, input logic [1:0] kind);
      logic [1:0]  exp_trap;
      logic [31:0] exp_addr;
      int          wait_n;
      bit          seen;
      logic [1:0]  got_trap;
      logic [31:0] got_lin;
      int          pulses;
      @(negedge clk);
      hs_n      = 0;
      req_seg   = 13'(seg);
      req_off   = off;
      req_kind  = kind;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready, "R10 busy after accept", 32'(req_ready), 32'h0);
      seen = 0; pulses = 0; got_trap = '0; got_lin = '0;
      for (wait_n = 0; wait_n < 60; wait_n++) begin
         if (out_valid) begin
            pulses++;
            if (!seen) begin got_trap = out_trap; got_lin = out_lin; end
            seen = 1;
         end
         if (seen && !out_valid) break;
         @(negedge clk);
      end
      check(seen && pulses == 1, "R10 one result pulse", 32'(pulses), 32'h1);
      if (seg >= int'(tbl_len))                   exp_trap = 2'd1;
      else if (off > {1'b0, lim_of(seg)})         exp_trap = 2'd2;
      else if (kind == 2'd1 && (seg % 2) == 1)    exp_trap = 2'd3;
      else                                        exp_trap = 2'd0;
      if (exp_trap == 2'd1) begin
         check(got_trap == 2'd1, "R2 bad selector code", 32'(got_trap), 32'h1);
         check(hs_n == 0, "R2 no memory read", 32'(hs_n), 32'h0);
      end else begin
         exp_addr = tbl_base + 32'(seg) * 8;
         check(hs_n == 2, "R3 two reads", 32'(hs_n), 32'h2);
         check(hs_addr0 == exp_addr, "R3 base word address", hs_addr0, exp_addr);
         check(hs_addr1 == exp_addr + 4, "R3 limit word address", hs_addr1, exp_addr + 4);
         if (exp_trap == 2'd2)
            check(got_trap == 2'd2, "R5 R8 limit code", 32'(got_trap), 32'h2);
         else if (exp_trap == 2'd3)
            check(got_trap == 2'd3, "R7 protection code", 32'(got_trap), 32'h3);
         else begin
            check(got_trap == 2'd0, "R6 R7 R9 accepted", 32'(got_trap), 32'h0);
            check(got_lin == base_of(seg) + off, "R9 linear address", got_lin, base_of(seg) + off);
         end
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!out_valid && !mem_req_valid && req_ready, "R1 reset state",
            {29'h0, out_valid, mem_req_valid, req_ready}, 32'h1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !mem_req_valid && req_ready, "R1 idle after reset",
            {29'h0, out_valid, mem_req_valid, req_ready}, 32'h1);
      for (int s = 0; s < 15; s++) begin
         for (int k = 0; k < 4; k++) begin
            logic [31:0] lim;
            lim = {1'b0, lim_of(s)};
            run(s, 32'h0, 2'(k));
            run(s, lim, 2'(k));
            run(s, lim + 1, 2'(k));
            run(s, 32'hFFFF_FFFF, 2'(k));
         end
      end
      tbl_len = 13'd0;
      run(0, 32'h0, 2'd0);
      tbl_len = 13'd12;
      tbl_base = 32'h0001_0000;
      run(3, 32'h10, 2'd2);
      run(7, 32'h7FFF_FFFF, 2'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule